// File: doc/BRIEF.md
# Write-Only Delay Chip Bring-Up Sequencer

This block brings a four-channel programmable clock-delay chip out of power-on. The chip takes one reset pulse per power cycle, and its delay settings can be written but not read back. After a start request the sequencer waits a fixed settling time and pulses the chip reset. It waits the same time again and then writes each channel's delay setting through a byte-level I2C command port. A separate bit-level engine outside this block serves that port.

Software stages the delay values in a register bank. Each value that the chip acknowledges is copied into a shadow register, which is the only readback of what the chip holds. A watchdog checks that a toggling clock-present input keeps changing. If it stops for longer than a programmed number of cycles, the block records a fault that halts the sequence. Only a global reset clears that fault.

Top module: `dlychip_bringup`

## Requirements
- R1: After `start` is accepted in the idle state, `chip_reset` stays low for WAIT_CYC cycles and is then high for exactly RST_CYC cycles.
- R2: `chip_reset` pulses at most once between global resets. A `start` seen while the sequencer is not idle, or while `clk_fault` is set, raises `req_refused` for one cycle in the following cycle and has no other effect.
- R3: After `chip_reset` falls, `cmd_valid` rises exactly WAIT_CYC cycles later.
- R4: Each channel is written as three bytes, and channels go out in the order 0, 1, 2, 3. The first byte is the device address shifted left with a zero write bit (0x54 by default) and has `cmd_first` set. The second byte is the channel number (0 to 3). The third byte is the delay setting and has `cmd_last` set. A byte and its flags stay stable while `cmd_valid` is high and `cmd_ready` is low.
- R5: A response with `resp_ack` low sets `nack_err`. No further byte is offered after that, and `done` never rises.
- R6: `done` rises only after the delay byte of channel 3 has been acknowledged.
- R7: `rd_data` returns the acknowledged delay byte of channel `rd_ch`, or zero after reset. Staging writes never change it.
- R8: The delay byte sent is the staged value at the moment the channel's index byte is acknowledged. A staging write in that same cycle is kept for later but is neither sent nor shadowed.
- R9: `clk_fault` is set once `clk_present` has not toggled for `cfg_timeout` cycles after a two-stage synchronizer. It then stays set until `rst_n`. One cycle after it is set, `busy`, `cmd_valid` and `chip_reset` are low.
- R10: `busy` is high from the accepted start until the sequence ends in done, NACK or fault. After reset, all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Global power-on reset, active low |
| start | input | 1 | Request to run the bring-up sequence |
| cfg_we | input | 1 | Staging write strobe |
| cfg_ch | input | 2 | Staging write channel |
| cfg_wdata | input | 8 | Staging write delay value |
| rd_ch | input | 2 | Shadow readback channel select |
| rd_data | output | 8 | Shadow readback value |
| cmd_valid | output | 1 | Command byte offered to the I2C engine |
| cmd_ready | input | 1 | I2C engine takes the byte |
| cmd_byte | output | 8 | Command byte |
| cmd_first | output | 1 | Byte opens a transaction (start condition) |
| cmd_last | output | 1 | Byte closes a transaction (stop condition) |
| resp_valid | input | 1 | Acknowledge result for the last byte is present |
| resp_ack | input | 1 | 1 = ACK, 0 = NACK |
| chip_reset | output | 1 | Reset pulse to the delay chip, active high |
| clk_present | input | 1 | Toggling sign of life of the chip's clock |
| cfg_timeout | input | 16 | Clock-loss timeout in cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All channels programmed |
| nack_err | output | 1 | Sequence stopped on NACK |
| clk_fault | output | 1 | Clock loss latched; needs a power cycle |
| req_refused | output | 1 | A start request was refused |

## Verification
Two functions can meet in one cycle: a staging write and the latching of a channel's delay byte. The bench's I2C responder raises a staging write to channel 1 in the same cycle that it acknowledges channel 1's index byte. It then checks that the old value is the one sent and shadowed, while the new value remains staged. A reference model steps every cycle and compares all outputs. Separate scenarios cover a NACK partway through the sequence and a clock loss during the post-reset wait, each followed by a refused start.

// File: rtl/dlychip_pkg.sv
package dlychip_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_WAIT,
    ST_PULSE,
    ST_POST_WAIT,
    ST_SEND,
    ST_RESP,
    ST_DONE,
    ST_NACK,
    ST_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_INDEX,
    BY_DELAY
  } byte_sel_e;

endpackage

// File: rtl/dly_wait_timer.sv
module dly_wait_timer #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == limit - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (run && !expired) cnt_d = cnt_q + CNT_W'(1);
    else                 cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dly_clk_watch.sv
module dly_clk_watch #(
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_present,
  input  logic [TO_W-1:0] timeout,
  output logic            fault
);

  logic [SYNC_STAGES:0] chain_q;
  logic [TO_W-1:0]      idle_q, idle_d;
  logic                 fault_q, fault_d;
  logic                 toggle;

  assign toggle = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];

  always_comb begin
    idle_d  = idle_q;
    fault_d = fault_q | (idle_q >= timeout);
    if (toggle)         idle_d = '0;
    else if (!(&idle_q)) idle_d = idle_q + TO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      idle_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-1:0], clk_present};
      idle_q  <= idle_d;
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);

endmodule

// File: rtl/dly_shadow_bank.sv
module dly_shadow_bank #(
  parameter int N_CH = 4,
  parameter int DW   = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_ch,
  input  logic [DW-1:0]            cfg_wdata,
  input  logic                     commit,
  input  logic [CH_W-1:0]          commit_ch,
  input  logic [DW-1:0]            commit_data,
  input  logic [CH_W-1:0]          rd_ch,
  output logic [DW-1:0]            rd_data,
  output logic [N_CH-1:0][DW-1:0]  stage
);

  logic [N_CH-1:0][DW-1:0] shadow;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [DW-1:0] stg_q, shd_q;
    logic          stg_en, shd_en;

    assign stg_en = cfg_we && (cfg_ch == CH_W'(g));
    assign shd_en = commit && (commit_ch == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
        shd_q <= '0;
      end else begin
        if (stg_en) stg_q <= cfg_wdata;
        if (shd_en) shd_q <= commit_data;
      end
    end

    assign stage[g]  = stg_q;
    assign shadow[g] = shd_q;
  end

  assign rd_data = shadow[rd_ch];

endmodule

// File: rtl/dly_seq_fsm.sv
module dly_seq_fsm
  import dlychip_pkg::*;
#(
  parameter int           N_CH     = 4,
  parameter int           DW       = 8,
  parameter int           CNT_W    = 26,
  parameter int           WAIT_CYC = 50_000_000,
  parameter int           RST_CYC  = 16,
  parameter logic [6:0]   DEV_ADDR = 7'h2A,
  localparam int          CH_W     = $clog2(N_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    fault,
  input  logic                    expired,
  output logic                    run,
  output logic [CNT_W-1:0]        limit,
  input  logic                    cmd_ready,
  input  logic                    resp_valid,
  input  logic                    resp_ack,
  input  logic [N_CH-1:0][DW-1:0] stage,
  output logic                    cmd_valid,
  output logic [DW-1:0]           cmd_byte,
  output logic                    cmd_first,
  output logic                    cmd_last,
  output logic                    commit,
  output logic [CH_W-1:0]         commit_ch,
  output logic [DW-1:0]           commit_data,
  output logic                    chip_reset,
  output logic                    busy,
  output logic                    done,
  output logic                    nack_err,
  output logic                    req_refused
);

  localparam logic [DW-1:0]   ADDR_BYTE = DW'({DEV_ADDR, 1'b0});
  localparam logic [CH_W-1:0] LAST_CH   = CH_W'(N_CH - 1);

  seq_state_e      st_q, st_d;
  byte_sel_e       sel_q, sel_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [DW-1:0]   byte_q, byte_d;
  logic            ref_q, ref_d;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    ch_d   = ch_q;
    byte_d = byte_q;
    commit = 1'b0;
    ref_d  = start && ((st_q != ST_IDLE) || fault);
    if (fault && (st_q != ST_FAULT)) begin
      st_d = ST_FAULT;
    end else begin
      unique case (st_q)
        ST_IDLE:      if (start)   st_d = ST_PRE_WAIT;
        ST_PRE_WAIT:  if (expired) st_d = ST_PULSE;
        ST_PULSE:     if (expired) st_d = ST_POST_WAIT;
        ST_POST_WAIT: if (expired) begin
          st_d   = ST_SEND;
          ch_d   = '0;
          sel_d  = BY_ADDR;
          byte_d = ADDR_BYTE;
        end
        ST_SEND:      if (cmd_ready) st_d = ST_RESP;
        ST_RESP:      if (resp_valid) begin
          if (!resp_ack) begin
            st_d = ST_NACK;
          end else begin
            unique case (sel_q)
              BY_ADDR: begin
                sel_d  = BY_INDEX;
                byte_d = DW'(ch_q);
                st_d   = ST_SEND;
              end
              BY_INDEX: begin
                sel_d  = BY_DELAY;
                byte_d = stage[ch_q];
                st_d   = ST_SEND;
              end
              default: begin
                commit = 1'b1;
                if (ch_q == LAST_CH) begin
                  st_d = ST_DONE;
                end else begin
                  ch_d   = ch_q + CH_W'(1);
                  sel_d  = BY_ADDR;
                  byte_d = ADDR_BYTE;
                  st_d   = ST_SEND;
                end
              end
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= BY_ADDR;
      ch_q   <= '0;
      byte_q <= '0;
      ref_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      ch_q   <= ch_d;
      byte_q <= byte_d;
      ref_q  <= ref_d;
    end
  end

  assign run         = (st_q == ST_PRE_WAIT) || (st_q == ST_PULSE) || (st_q == ST_POST_WAIT);
  assign limit       = (st_q == ST_PULSE) ? CNT_W'(RST_CYC) : CNT_W'(WAIT_CYC);
  assign cmd_valid   = (st_q == ST_SEND);
  assign cmd_byte    = byte_q;
  assign cmd_first   = (sel_q == BY_ADDR);
  assign cmd_last    = (sel_q == BY_DELAY);
  assign commit_ch   = ch_q;
  assign commit_data = byte_q;
  assign chip_reset  = (st_q == ST_PULSE);
  assign busy        = run || (st_q == ST_SEND) || (st_q == ST_RESP);
  assign done        = (st_q == ST_DONE);
  assign nack_err    = (st_q == ST_NACK);
  assign req_refused = ref_q;

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !fault) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_last)));

  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(resp_valid && resp_ack));

  assert_nack_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> $past(resp_valid && !resp_ack));

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && $past(fault)) |-> (!cmd_valid && !chip_reset && !busy));

  assert_pulse_after_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_reset) |-> $past(expired));

endmodule

// File: rtl/dlychip_bringup.sv
module dlychip_bringup #(
  parameter int         N_CH        = 4,
  parameter int         DW          = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         WAIT_CYC    = 50_000_000,
  parameter int         RST_CYC     = 16,
  parameter int         TO_W        = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    cfg_we,
  input  logic [$clog2(N_CH)-1:0] cfg_ch,
  input  logic [DW-1:0]           cfg_wdata,
  input  logic [$clog2(N_CH)-1:0] rd_ch,
  output logic [DW-1:0]           rd_data,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [DW-1:0]           cmd_byte,
  output logic                    cmd_first,
  output logic                    cmd_last,
  input  logic                    resp_valid,
  input  logic                    resp_ack,
  output logic                    chip_reset,
  input  logic                    clk_present,
  input  logic [TO_W-1:0]         cfg_timeout,
  output logic                    busy,
  output logic                    done,
  output logic                    nack_err,
  output logic                    clk_fault,
  output logic                    req_refused
);

  localparam int CH_W  = $clog2(N_CH);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic [1:0]              rs_q;
  logic                    rst_i;
  logic                    run, expired, fault, commit;
  logic [CNT_W-1:0]        limit;
  logic [CH_W-1:0]         commit_ch;
  logic [DW-1:0]           commit_data;
  logic [N_CH-1:0][DW-1:0] stage;
  logic                    rst_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  dly_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_i), .run(run), .limit(limit), .expired(expired)
  );

  dly_clk_watch #(.TO_W(TO_W), .SYNC_STAGES(SYNC_STAGES)) u_watch (
    .clk(clk), .rst_n(rst_i), .clk_present(clk_present),
    .timeout(cfg_timeout), .fault(fault)
  );

  dly_shadow_bank #(.N_CH(N_CH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_i),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
    .commit(commit), .commit_ch(commit_ch), .commit_data(commit_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .stage(stage)
  );

  dly_seq_fsm #(
    .N_CH(N_CH), .DW(DW), .CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC),
    .RST_CYC(RST_CYC), .DEV_ADDR(DEV_ADDR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_i), .start(start), .fault(fault),
    .expired(expired), .run(run), .limit(limit),
    .cmd_ready(cmd_ready), .resp_valid(resp_valid), .resp_ack(resp_ack),
    .stage(stage), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_first(cmd_first), .cmd_last(cmd_last),
    .commit(commit), .commit_ch(commit_ch), .commit_data(commit_data),
    .chip_reset(chip_reset), .busy(busy), .done(done),
    .nack_err(nack_err), .req_refused(req_refused)
  );

  assign clk_fault = fault;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)          rst_seen_q <= 1'b0;
    else if (chip_reset) rst_seen_q <= 1'b1;
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(chip_reset) |-> !rst_seen_q);

endmodule

// File: tb/tb_dlychip_bringup.sv
module tb_dlychip_bringup;

  localparam int WC = 40;
  localparam int RC = 5;

  logic       clk;
  logic       rst_n, start;
  logic       main_we, coll_we, cfg_we;
  logic [1:0] main_ch, coll_ch, cfg_ch, rd_ch;
  logic [7:0] main_wd, coll_wd, cfg_wdata, rd_data;
  logic       cmd_valid, cmd_ready, cmd_first, cmd_last;
  logic [7:0] cmd_byte;
  logic       resp_valid, resp_ack, chip_reset, clk_present;
  logic [15:0] cfg_timeout;
  logic       busy, done, nack_err, clk_fault, req_refused;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit tog_en = 1;
  int tcnt = 0;
  bit coll_en = 0;
  int nack_byte = -1;
  int nseen;
  logic [7:0] log_b[$];
  bit log_f[$], log_l[$];

  assign cfg_we    = main_we | coll_we;
  assign cfg_ch    = coll_we ? coll_ch : main_ch;
  assign cfg_wdata = coll_we ? coll_wd : main_wd;

  dlychip_bringup #(.WAIT_CYC(WC), .RST_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .cmd_first(cmd_first), .cmd_last(cmd_last), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .chip_reset(chip_reset), .clk_present(clk_present),
    .cfg_timeout(cfg_timeout), .busy(busy), .done(done), .nack_err(nack_err),
    .clk_fault(clk_fault), .req_refused(req_refused)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R6 watchdog act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  // clock-present toggle source
  initial clk_present = 0;
  always @(negedge clk) begin
    if (tog_en) begin
      tcnt++;
      if (tcnt >= 3) begin
        tcnt = 0;
        clk_present = ~clk_present;
      end
    end
  end

  // reference model: 0 idle 1 pre 2 pulse 3 post 4 send 5 resp 6 done 7 nack 8 fault
  int m_rc, m_st, m_tmr, m_ch, m_sel, m_byte, m_wc;
  bit m_ref, m_fault, m_s1, m_s2, m_s3;
  int m_stage[4], m_shd[4];

  always @(posedge clk) begin
    int nst, nch, nsel, nbyte, lim;
    bit run, ex, tog, nf;
    if (!rst_n || m_rc < 2) begin
      if (!rst_n) m_rc = 0; else m_rc++;
      m_st = 0; m_tmr = 0; m_ch = 0; m_sel = 0; m_byte = 0; m_wc = 0;
      m_ref = 0; m_fault = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      foreach (m_stage[i]) begin m_stage[i] = 0; m_shd[i] = 0; end
    end else begin
      run = (m_st >= 1 && m_st <= 3);
      lim = (m_st == 2) ? RC : WC;
      ex  = run && (m_tmr == lim - 1);
      nst = m_st; nch = m_ch; nsel = m_sel; nbyte = m_byte;
      if (m_fault && m_st != 8) nst = 8;
      else case (m_st)
        0: if (start) nst = 1;
        1: if (ex) nst = 2;
        2: if (ex) nst = 3;
        3: if (ex) begin nst = 4; nch = 0; nsel = 0; nbyte = 8'h54; end
        4: if (cmd_ready) nst = 5;
        5: if (resp_valid) begin
             if (!resp_ack) nst = 7;
             else if (m_sel == 0) begin nsel = 1; nbyte = m_ch; nst = 4; end
             else if (m_sel == 1) begin nsel = 2; nbyte = m_stage[m_ch]; nst = 4; end
             else begin
               m_shd[m_ch] = m_byte;
               if (m_ch == 3) nst = 6;
               else begin nch = m_ch + 1; nsel = 0; nbyte = 8'h54; nst = 4; end
             end
           end
        default: ;
      endcase
      m_ref = start && (m_st != 0 || m_fault);
      m_tmr = (run && !ex) ? m_tmr + 1 : 0;
      tog = (m_s2 != m_s3);
      nf  = m_fault || (m_wc >= int'(cfg_timeout));
      m_wc = tog ? 0 : m_wc + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = clk_present;
      m_fault = nf;
      if (cfg_we) m_stage[cfg_ch] = cfg_wdata;
      m_st = nst; m_ch = nch; m_sel = nsel; m_byte = nbyte;
    end
  end

  always @(posedge clk) begin
    #5;
    chk(chip_reset, m_st == 2, "R1 chip_reset");
    chk(busy, m_st >= 1 && m_st <= 5, "R10 busy");
    chk(done, m_st == 6, "R6 done");
    chk(nack_err, m_st == 7, "R5 nack_err");
    chk(clk_fault, m_fault, "R9 clk_fault");
    chk(cmd_valid, m_st == 4, "R3 cmd_valid");
    if (cmd_valid) begin
      chk(cmd_byte, m_byte, "R4 R8 cmd_byte");
      chk(cmd_first, m_sel == 0, "R4 cmd_first");
      chk(cmd_last, m_sel == 2, "R4 cmd_last");
    end
    chk(rd_data, m_shd[rd_ch], "R7 rd_data");
    chk(req_refused, m_ref, "R2 req_refused");
  end

  // I2C byte responder
  initial begin
    cmd_ready = 0; resp_valid = 0; resp_ack = 0;
    coll_we = 0; coll_ch = 0; coll_wd = 0; nseen = 0;
    forever begin
      @(negedge clk);
      cmd_ready = 0; resp_valid = 0; coll_we = 0;
      if (!rst_n) begin
        nseen = 0;
        log_b.delete(); log_f.delete(); log_l.delete();
      end else if (cmd_valid) begin
        repeat (nseen % 3) @(negedge clk);
        log_b.push_back(cmd_byte); log_f.push_back(cmd_first); log_l.push_back(cmd_last);
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
        repeat ((nseen + 1) % 2) @(negedge clk);
        resp_valid = 1;
        resp_ack = (nseen != nack_byte);
        if (coll_en && nseen == 4) begin
          coll_we = 1; coll_ch = 2'd1; coll_wd = 8'h1C;
        end
        nseen++;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #6;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic stage_all(input logic [7:0] v0, v1, v2, v3);
    logic [7:0] v[4];
    v = '{v0, v1, v2, v3};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); main_we = 1; main_ch = 2'(i); main_wd = v[i];
    end
    @(negedge clk); main_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!done && !nack_err && !clk_fault && n < 3000) begin tick(); n++; end
  endtask

  initial begin
    int n;
    logic [7:0] exp_b[$];
    rst_n = 0; start = 0; main_we = 0; main_ch = 0; main_wd = 0; rd_ch = 0;
    cfg_timeout = 16'd12;
    apply_reset();

    // reset state R10 R7
    tick();
    chk(busy, 0, "R10 reset busy");
    chk(done, 0, "R10 reset done");
    chk(chip_reset, 0, "R10 reset chip_reset");
    chk(clk_fault, 0, "R10 reset clk_fault");
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); rd_ch = 2'(c); tick();
      chk(rd_data, 0, "R7 reset shadow");
    end

    // scenario 1: full bring-up with collision on channel 1
    stage_all(8'h11, 8'h05, 8'h1F, 8'h0A);
    coll_en = 1;
    pulse_start();
    n = 0;
    do begin tick(); n++; end while (!chip_reset && n < 500);
    chk(n, WC, "R1 pre-reset wait");
    n = 0;
    while (chip_reset && n < 500) begin tick(); n++; end
    chk(n, RC, "R1 pulse width");
    n = 0;
    while (!cmd_valid && n < 500) begin tick(); n++; end
    chk(n, WC, "R3 post-reset wait");
    wait_end();
    chk(done, 1, "R6 done after four channels");
    chk(nack_err, 0, "R5 no nack");
    exp_b = '{8'h54, 8'h00, 8'h11, 8'h54, 8'h01, 8'h05,
              8'h54, 8'h02, 8'h1F, 8'h54, 8'h03, 8'h0A};
    chk(log_b.size(), 12, "R4 byte count");
    for (int i = 0; i < 12 && i < log_b.size(); i++) begin
      chk(log_b[i], exp_b[i], "R4 byte order");
      chk(log_f[i], (i % 3) == 0, "R4 first flag");
      chk(log_l[i], (i % 3) == 2, "R4 last flag");
    end
    @(negedge clk); rd_ch = 2'd1; tick();
    chk(rd_data, 8'h05, "R8 collided write not shadowed");
    @(negedge clk); rd_ch = 2'd3; tick();
    chk(rd_data, 8'h0A, "R7 shadow ch3");
    @(negedge clk); main_we = 1; main_ch = 2'd2; main_wd = 8'h07; rd_ch = 2'd2;
    @(negedge clk); main_we = 0;
    tick();
    chk(rd_data, 8'h1F, "R7 staging write ignored by shadow");
    coll_en = 0;
    @(negedge clk); start = 1;
    @(posedge clk); #6;
    chk(req_refused, 1, "R2 second start refused");
    @(negedge clk); start = 0;
    n = 0;
    for (int i = 0; i < 60; i++) begin tick(); if (chip_reset || busy) n++; end
    chk(n, 0, "R2 no second reset");

    // scenario 2: NACK on channel 1 delay byte
    nack_byte = 5;
    apply_reset();
    stage_all(8'h03, 8'h09, 8'h0C, 8'h0E);
    pulse_start();
    wait_end();
    chk(nack_err, 1, "R5 nack latched");
    chk(done, 0, "R5 no done after nack");
    @(negedge clk); rd_ch = 2'd0; tick();
    chk(rd_data, 8'h03, "R7 ch0 shadowed");
    @(negedge clk); rd_ch = 2'd1; tick();
    chk(rd_data, 8'h00, "R5 ch1 not shadowed");
    n = 0;
    for (int i = 0; i < 30; i++) begin tick(); if (cmd_valid) n++; end
    chk(n, 0, "R5 no byte after nack");
    chk(log_b.size(), 6, "R5 bytes before stop");

    // scenario 3: clock loss during post-reset wait
    nack_byte = -1;
    apply_reset();
    stage_all(8'h01, 8'h02, 8'h03, 8'h04);
    pulse_start();
    n = 0;
    while (!chip_reset && n < 500) begin tick(); n++; end
    while (chip_reset && n < 500) begin tick(); n++; end
    @(negedge clk); tog_en = 0;
    n = 0;
    while (!clk_fault && n < 60) begin tick(); n++; end
    chk(clk_fault, 1, "R9 fault on clock loss");
    chk(n <= 12 + 6, 1, "R9 fault latency");
    n = 0;
    for (int i = 0; i < 60; i++) begin tick(); if (cmd_valid || busy || chip_reset) n++; end
    chk(n, 0, "R9 sequence halted");
    @(negedge clk); tog_en = 1;
    repeat (20) tick();
    chk(clk_fault, 1, "R9 fault sticky");
    @(negedge clk); start = 1;
    @(posedge clk); #6;
    chk(req_refused, 1, "R2 start refused on fault");
    @(negedge clk); start = 0;
    apply_reset();
    tick();
    chk(clk_fault, 0, "R9 cleared by global reset");

    repeat (5) tick();
    summary();
    $finish;
  end

endmodule